// File: doc/BRIEF.md
# Calibration Start Controller with Shadowed Settings

This block holds the settings of an oscillator calibration engine in two copies. Register writes land in a buffered copy and change nothing downstream. A separate update command copies the whole buffer into the active copy in one step, so several fields change together. The update command clears itself.

The active copy drives two things. The first is a calibration start pulse. That pulse fires only when the active start bit changes from 0 to 1, and only while a reference-present input is high. The second is a periodic enable tick whose period is 2, 4, 8 or 16 cycles of the reference clock. The calibration engine uses that tick as its slow clock. A busy flag rises with the start pulse and stays high until the engine returns a done strobe. To start a calibration, software writes start=0, issues an update, then writes start=1 and issues a second update. The block runs entirely on the reference clock.

Top module: `cal_shadow_ctrl`

## Requirements
- R1: After reset, the active divide code is 3, the active start bit is 0, and busy, start pulse and update-pending are all 0.
- R2: A write to address 0 loads only the buffered copy (start at data bit 0, divide code at data bits 2:1). The active outputs do not change until an update.
- R3: Writing 1 to bit 0 of address 1 raises update-pending for one cycle. On the next edge the buffered values move into the active copy, and update-pending returns to 0 unless another update is written.
- R4: A 0-to-1 change of the active start bit, with the reference present and the block not busy, gives a start pulse exactly one cycle wide. The pulse appears one edge after the active bit changes.
- R5: An update that leaves the active start bit at 1 produces no start pulse. The bit's level alone never triggers a calibration.
- R6: A start edge that occurs while the reference-present input is low is dropped. A new 0-to-1 sequence is needed afterwards.
- R7: Busy rises together with the start pulse and falls on the edge after the done input is sampled high. Start edges that occur while busy is high give no pulse.
- R8: The calibration tick repeats every 2, 4, 8 or 16 cycles for active divide codes 0, 1, 2 and 3.
- R9: The calibration tick is high for one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = settings buffer, 1 = update command |
| wr_data | input | 8 | Write data |
| ref_ok | input | 1 | Reference clock present |
| cal_done | input | 1 | Calibration finished strobe |
| upd_pending | output | 1 | Update command in progress |
| act_start | output | 1 | Active start bit |
| act_div | output | 2 | Active divide code |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_busy | output | 1 | Calibration in progress |
| cal_clk_en | output | 1 | Divided calibration tick |

## Verification
The bench walks all four divide codes in turn. At each step it checks that the active code stays put until the update and then takes the new value. It also measures the spacing between ticks, which tells a wrong ratio apart from a wrong code decode. The start logic is tried with five patterns: a proper 0-then-1 sequence, a repeated update with the bit held at 1, an edge made while busy, an edge made with the reference absent, and a fresh sequence afterwards. Together these separate edge triggering from level triggering and show the busy and reference gates each working alone.

// File: rtl/cal_shadow_ctrl.sv
module cal_shadow_ctrl #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ref_ok,
  input  logic              cal_done,
  output logic              upd_pending,
  output logic              act_start,
  output logic [DIV_W-1:0]  act_div,
  output logic              cal_start,
  output logic              cal_busy,
  output logic              cal_clk_en
);
  localparam int CNT_W = 2 ** DIV_W;
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  logic             buf_start;
  logic [DIV_W-1:0] buf_div;
  logic             start_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   ratio;
  logic             rise;

  assign ratio      = (CNT_W+1)'(2) << act_div;
  assign cal_clk_en = ({1'b0, cnt} >= ratio - 1'b1);
  assign rise       = act_start && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_start   <= 1'b0;
      buf_div     <= DIV_RST;
      act_start   <= 1'b0;
      act_div     <= DIV_RST;
      upd_pending <= 1'b0;
      start_q     <= 1'b0;
      cal_start   <= 1'b0;
      cal_busy    <= 1'b0;
      cnt         <= '0;
    end else begin
      if (wr_en && !wr_addr) begin
        buf_start <= wr_data[0];
        buf_div   <= wr_data[DIV_W:1];
      end
      upd_pending <= wr_en && wr_addr && wr_data[0];
      if (upd_pending) begin
        act_start <= buf_start;
        act_div   <= buf_div;
      end
      start_q   <= act_start;
      cal_start <= rise && ref_ok && !cal_busy;
      if (rise && ref_ok && !cal_busy) cal_busy <= 1'b1;
      else if (cal_done)               cal_busy <= 1'b0;
      cnt <= cal_clk_en ? '0 : cnt + 1'b1;
    end
  end
endmodule

module cal_shadow_ctrl_chk #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_pending,
  input logic             act_start,
  input logic [DIV_W-1:0] act_div,
  input logic [DIV_W-1:0] buf_div,
  input logic             cal_start,
  input logic             cal_busy,
  input logic             cal_done,
  input logic             cal_clk_en
);
  // R2
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pending |=> ($stable(act_div) && $stable(act_start)));
  // R3
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pending |=> (act_div == $past(buf_div)));
  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);
  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> cal_busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> cal_busy);
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |=> !cal_start);
  // R9
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_clk_en |=> !cal_clk_en);
endmodule

bind cal_shadow_ctrl cal_shadow_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_pending(upd_pending), .act_start(act_start),
  .act_div(act_div), .buf_div(buf_div), .cal_start(cal_start),
  .cal_busy(cal_busy), .cal_done(cal_done), .cal_clk_en(cal_clk_en)
);

// File: tb/cal_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module cal_shadow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ref_ok = 1'b1;
  logic       cal_done = 1'b0;
  logic       upd_pending, act_start, cal_start, cal_busy, cal_clk_en;
  logic [1:0] act_div;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cal_shadow_ctrl u_cal_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ref_ok(ref_ok), .cal_done(cal_done),
    .upd_pending(upd_pending), .act_start(act_start), .act_div(act_div),
    .cal_start(cal_start), .cal_busy(cal_busy), .cal_clk_en(cal_clk_en)
  );

  // {divide code, expected period}
  localparam logic [1:0] DIV_CODE [4] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int         DIV_RAT  [4] = '{2, 4, 8, 16};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd_count(output int pulses, output int first_at);
    pulses = 0; first_at = -1;
    wr(1'b1, 8'h01);
    for (int k = 1; k <= 6; k++) begin
      if (cal_start) begin
        pulses++;
        if (first_at < 0) first_at = k;
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    int p, f, prev, gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 div", act_div, 3);
    check("R1 start", act_start, 0);
    check("R1 busy", cal_busy, 0);
    check("R1 pulse", cal_start, 0);
    check("R1 upd", upd_pending, 0);

    prev = 3;
    for (int i = 0; i < 4; i++) begin
      wr(1'b0, {5'd0, DIV_CODE[i], 1'b0});
      check("R2 hold", act_div, prev);
      wr(1'b1, 8'h01);
      check("R3 pending", upd_pending, 1);
      @(negedge clk);
      check("R3 transfer", act_div, DIV_CODE[i]);
      check("R3 selfclear", upd_pending, 0);
      repeat (20) @(negedge clk);
      while (!cal_clk_en) @(negedge clk);
      @(negedge clk);
      check("R9 width", cal_clk_en, 0);
      gap = 1;
      while (!cal_clk_en) begin @(negedge clk); gap++; end
      check("R8 period", gap, DIV_RAT[i]);
      prev = DIV_CODE[i];
    end

    wr(1'b0, 8'h06); upd_count(p, f);
    check("R4 no pulse on 0", p, 0);
    wr(1'b0, 8'h07); upd_count(p, f);
    check("R4 one pulse", p, 1);
    check("R4 timing", f, 3);
    check("R7 busy", cal_busy, 1);

    wr(1'b0, 8'h06); upd_count(p, f);
    wr(1'b0, 8'h07); upd_count(p, f);
    check("R7 ignored while busy", p, 0);
    check("R7 still busy", cal_busy, 1);

    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
    check("R7 busy clears", cal_busy, 0);

    upd_count(p, f);
    check("R5 level no pulse", p, 0);
    check("R5 start held", act_start, 1);

    ref_ok = 1'b0;
    wr(1'b0, 8'h06); upd_count(p, f);
    wr(1'b0, 8'h07); upd_count(p, f);
    check("R6 no ref", p, 0);
    check("R6 not busy", cal_busy, 0);
    ref_ok = 1'b1;
    upd_count(p, f);
    check("R6 dropped edge", p, 0);

    wr(1'b0, 8'h06); upd_count(p, f);
    wr(1'b0, 8'h07); upd_count(p, f);
    check("R4 restart", p, 1);
    check("R7 busy again", cal_busy, 1);

    finish_run();
  end
endmodule